// File: doc/BRIEF.md
# Divided Countdown Timer with Interrupt Entry

The block is a per-core countdown timer. Software loads a start value, picks a prescale ratio with a small divide-configuration register, and fills in a timer entry that holds the interrupt vector, a mask bit and a periodic-mode bit. The count then decreases by one on every divided tick. When it expires, the block issues a single-cycle, edge-style, fixed-delivery request that carries the entry's vector.

In one-shot mode the count halts at zero. In periodic mode it reloads from the start value in the same cycle that the request is issued. The request goes out only while the controller is enabled by both its hardware and its software enable, and only while the entry is unmasked. When software enable is low, the entry is held masked. The current count, the start value, the divide setting and the entry are all visible on output ports. An address decoder outside the block turns bus accesses into the write strobes this block receives.

Top module: `local_timer_div`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked), the divide setting and the start value are 0, the current count is 0 and no request is pending.
- R2: The divide field is {cfg[3], cfg[1], cfg[0]}. The shift s equals (field + 1) mod 8, and the count steps once every 2^s clock cycles. Setting 4'b1011 gives divide by 1, 4'b0000 gives divide by 2, 4'b0011 gives divide by 16 and 4'b1000 gives divide by 32.
- R3: A start-value write of N loads the current count with N on the next edge and also restarts the prescaler. This happens whether or not a countdown was in progress. With ratio D, the count equals N-k exactly k·D cycles after the write.
- R4: In one-shot mode (entry bit 17 = 0), expiry occurs N·D cycles after the write. The count then stays at 0 and no further request follows.
- R5: In periodic mode (entry bit 17 = 1), the count reloads to N on the same edge that raises the request, so requests recur every N·D cycles.
- R6: A start value of 0 never starts the countdown and never raises a request. Writing 0 to a running timer stops it.
- R7: A request is raised on expiry only when hw_en = 1, sw_en = 1 and entry bit 16 (mask) = 0. The count behaves the same either way.
- R8: The entry stores only bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic). All other bits read as 0.
- R9: While sw_en = 0, the entry's mask bit is forced to 1. This applies both to the stored value and to any entry write made during that time.
- R10: Each request is a one-cycle pulse on irq_pulse. On that cycle, irq_vec equals entry bits 7:0 as they were when the timer expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Controller hardware enable |
| sw_en | input | 1 | Controller software enable |
| ent_wr | input | 1 | Write strobe for the timer entry |
| div_wr | input | 1 | Write strobe for the divide setting |
| init_wr | input | 1 | Write strobe for the start value |
| wr_data | input | 32 | Write data shared by all strobes |
| entry_q | output | 32 | Timer entry read-back |
| div_q | output | 4 | Divide setting read-back |
| init_q | output | CNT_W | Start value read-back |
| cur_cnt | output | CNT_W | Current count |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector of the request |

## Verification
The bench builds the block with CNT_W = 16, which keeps the start values short. The prescaler width still follows from the largest shift, so the divide-by-32 and divide-by-16 settings can be reached in a few dozen cycles, along with divide by 1 and divide by 2. A scoreboard records every expected request as a cycle number and a vector, computed from N·D. Any request that arrives early, late, with the wrong vector or while it is gated therefore shows up as a mismatch or an unexpected pulse.

// File: rtl/ltd_pkg.sv
package ltd_pkg;
  localparam int ENT_W        = 32;
  localparam int VEC_W        = 8;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;
  localparam int ENT_DS_BIT   = 12;
  localparam int SHIFT_W      = 3;
  localparam int PRE_W        = (1 << SHIFT_W) - 1;
  localparam logic [ENT_W-1:0] ENT_KEEP =
    (ENT_W'(1) << ENT_PER_BIT) | (ENT_W'(1) << ENT_MASK_BIT) |
    (ENT_W'(1) << ENT_DS_BIT)  | ENT_W'((1 << VEC_W) - 1);
  localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << ENT_MASK_BIT;

  // Shift amount from the split field {cfg[3], cfg[1], cfg[0]}, plus one, mod 8.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] fld;
    fld = {cfg[3], cfg[1], cfg[0]};
    return fld + SHIFT_W'(1);
  endfunction

  // Low-bit mask whose all-ones state marks one tick every 2^s cycles.
  function automatic logic [PRE_W-1:0] tick_mask(input logic [SHIFT_W-1:0] s);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << s;
    return PRE_W'(one_hot - (PRE_W+1)'(1));
  endfunction
endpackage

// File: rtl/ltd_entry_reg.sv
module ltd_entry_reg
  import ltd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             sw_en,
  output logic [ENT_W-1:0] entry_q
);
  logic [ENT_W-1:0] force_mask;
  logic [ENT_W-1:0] nxt;

  assign force_mask = sw_en ? '0 : ENT_RESET;

  always_comb begin
    nxt = entry_q;
    if (wr) nxt = wr_data & ENT_KEEP;
    nxt = nxt | force_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) entry_q <= ENT_RESET;
    else        entry_q <= nxt;
  end
endmodule

// File: rtl/ltd_prescaler.sv
module ltd_prescaler
  import ltd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] msk;

  assign msk  = tick_mask(shift);
  assign tick = (phase & msk) == msk;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase <= '0;
    else                   phase <= phase + PRE_W'(1);
  end
endmodule

// File: rtl/ltd_counter.sv
module ltd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  logic active;

  assign active = cur != '0;
  assign expire = tick && !load && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cur <= '0;
    else if (load)         cur <= load_val;
    else if (expire)       cur <= periodic ? reload_val : '0;
    else if (tick && active) cur <= cur - CNT_W'(1);
  end
endmodule

// File: rtl/local_timer_div.sv
module local_timer_div
  import ltd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic             ent_wr,
  input  logic             div_wr,
  input  logic             init_wr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      entry_q,
  output logic [3:0]       div_q,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec
);
  // Named internal events, observed by the bound checker.
  logic               tick_w;
  logic               expire_w;
  logic               grant_w;
  logic [SHIFT_W-1:0] shift_w;

  assign shift_w = div_shift(div_q);
  assign grant_w = expire_w && hw_en && sw_en && !entry_q[ENT_MASK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (div_wr)  div_q  <= wr_data[3:0];
      if (init_wr) init_q <= wr_data[CNT_W-1:0];
    end
  end

  ltd_entry_reg u_entry (
    .clk(clk), .rst_n(rst_n), .wr(ent_wr), .wr_data(wr_data),
    .sw_en(sw_en), .entry_q(entry_q)
  );

  ltd_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(init_wr), .shift(shift_w), .tick(tick_w)
  );

  ltd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(init_wr), .load_val(wr_data[CNT_W-1:0]),
    .reload_val(init_q), .tick(tick_w), .periodic(entry_q[ENT_PER_BIT]),
    .cur(cur_cnt), .expire(expire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
    end else begin
      irq_pulse <= grant_w;
      if (expire_w) irq_vec <= entry_q[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/ltd_checker.sv
module ltd_checker
  import ltd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_en,
  input logic             sw_en,
  input logic             init_wr,
  input logic [CNT_W-1:0] ld_val,
  input logic [31:0]      entry_q,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cur_cnt,
  input logic             irq_pulse,
  input logic [VEC_W-1:0] irq_vec,
  input logic             tick,
  input logic             expire
);
  a_r3_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> cur_cnt == $past(ld_val));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !init_wr && cur_cnt > CNT_W'(1)) |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt == '0 && !init_wr) |=> cur_cnt == '0);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry_q[ENT_PER_BIT]) |=> cur_cnt == init_q);

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(hw_en && sw_en && !entry_q[ENT_MASK_BIT]));

  a_r8_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_q & ~ENT_KEEP) == '0);

  a_r9_forced_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> entry_q[ENT_MASK_BIT]);

  a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_vec == $past(entry_q[VEC_W-1:0]));
endmodule

bind local_timer_div ltd_checker #(.CNT_W(CNT_W)) i_ltd_checker (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .init_wr(init_wr),
  .ld_val(wr_data[CNT_W-1:0]), .entry_q(entry_q), .init_q(init_q),
  .cur_cnt(cur_cnt), .irq_pulse(irq_pulse), .irq_vec(irq_vec),
  .tick(tick_w), .expire(expire_w)
);

// File: tb/test_local_timer_div.sv
`timescale 1ns/1ps
module test_local_timer_div;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_en = 1'b0, sw_en = 1'b0;
  logic          ent_wr = 1'b0, div_wr = 1'b0, init_wr = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   entry_q;
  logic [3:0]    div_q;
  logic [CW-1:0] init_q, cur_cnt;
  logic          irq_pulse;
  logic [7:0]    irq_vec;

  local_timer_div #(.CNT_W(CW)) i_local_timer_div (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .ent_wr(ent_wr), .div_wr(div_wr), .init_wr(init_wr), .wr_data(wr_data),
    .entry_q(entry_q), .div_q(div_q), .init_q(init_q), .cur_cnt(cur_cnt),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int at; logic [7:0] vec; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic push(input int at, input logic [7:0] v);
    exp_t e;
    e.at = at; e.vec = v;
    sb.push_back(e);
  endtask

  // Monitor: every request must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && irq_pulse) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected request", 32'(cyc), 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.at, "R4 request cycle", 32'(cyc), 32'(e.at));
        chk(irq_vec == e.vec, "R10 request vector", 32'(irq_vec), 32'(e.vec));
      end
    end
  end

  task automatic strobe(input int which, input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    ent_wr  = (which == 0);
    div_wr  = (which == 1);
    init_wr = (which == 2);
    @(negedge clk);
    ent_wr = 0; div_wr = 0; init_wr = 0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 32'(cyc), 32'd0);
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(entry_q == 32'h0001_0000, "R1 entry", entry_q, 32'h0001_0000);
    chk(div_q == 4'h0, "R1 divide", 32'(div_q), 0);
    chk(init_q == '0, "R1 start value", 32'(init_q), 0);
    chk(cur_cnt == '0, "R1 count", 32'(cur_cnt), 0);
    chk(irq_pulse == 1'b0, "R1 request", 32'(irq_pulse), 0);

    hw_en = 1; sw_en = 1;
    strobe(0, 32'hFFFF_FFFF);
    chk(entry_q == 32'h0003_10FF, "R8 kept bits", entry_q, 32'h0003_10FF);
    strobe(0, 32'h0000_0041);
    chk(entry_q == 32'h0000_0041, "R8 unmasked entry", entry_q, 32'h41);

    // Divide by 2 (reset setting), one-shot
    strobe(2, 32'd5); c0 = cyc; push(c0 + 10, 8'h41);
    chk(cur_cnt == CW'(5), "R3 load", 32'(cur_cnt), 5);
    wait_until(c0 + 9);
    chk(cur_cnt == CW'(1), "R3 step timing div2", 32'(cur_cnt), 1);
    wait_until(c0 + 10);
    chk(cur_cnt == '0, "R4 expiry count", 32'(cur_cnt), 0);
    wait_until(c0 + 20);
    chk(cur_cnt == '0, "R4 stays at zero", 32'(cur_cnt), 0);

    // Divide by 1
    strobe(1, 32'h0000_000B);
    chk(div_q == 4'hB, "R2 divide readback", 32'(div_q), 32'hB);
    strobe(0, 32'h0000_0052);
    strobe(2, 32'd3); c0 = cyc; push(c0 + 3, 8'h52);
    wait_until(c0 + 2);
    chk(cur_cnt == CW'(1), "R2 divide by 1", 32'(cur_cnt), 1);
    wait_until(c0 + 6);

    // Divide by 16
    strobe(1, 32'h0000_0003);
    strobe(2, 32'd2); c0 = cyc; push(c0 + 32, 8'h52);
    wait_until(c0 + 15);
    chk(cur_cnt == CW'(2), "R2 divide by 16 before tick", 32'(cur_cnt), 2);
    wait_until(c0 + 16);
    chk(cur_cnt == CW'(1), "R2 divide by 16 at tick", 32'(cur_cnt), 1);
    wait_until(c0 + 34);

    // Divide by 32
    strobe(1, 32'h0000_0008);
    strobe(2, 32'd1); c0 = cyc; push(c0 + 32, 8'h52);
    wait_until(c0 + 31);
    chk(cur_cnt == CW'(1), "R2 divide by 32 before tick", 32'(cur_cnt), 1);
    wait_until(c0 + 32);
    chk(cur_cnt == '0, "R2 divide by 32 expiry", 32'(cur_cnt), 0);
    wait_until(c0 + 34);

    // Periodic, divide by 1
    strobe(1, 32'h0000_000B);
    strobe(0, 32'h0002_0055);
    chk(entry_q == 32'h0002_0055, "R8 periodic entry", entry_q, 32'h0002_0055);
    strobe(2, 32'd4); c0 = cyc;
    push(c0 + 4, 8'h55); push(c0 + 8, 8'h55); push(c0 + 12, 8'h55);
    wait_until(c0 + 8);
    chk(cur_cnt == CW'(4), "R5 reload with request", 32'(cur_cnt), 4);
    wait_until(c0 + 12);
    chk(cur_cnt == CW'(4), "R5 second reload", 32'(cur_cnt), 4);
    strobe(2, 32'd0);
    chk(cur_cnt == '0, "R6 zero stops", 32'(cur_cnt), 0);
    repeat (20) @(negedge clk);
    chk(cur_cnt == '0, "R6 stays idle", 32'(cur_cnt), 0);

    // Restart while running
    strobe(0, 32'h0000_0066);
    strobe(2, 32'd10); c0 = cyc;
    wait_until(c0 + 4);
    chk(cur_cnt == CW'(6), "R3 mid-run count", 32'(cur_cnt), 6);
    strobe(2, 32'd3); c0 = cyc; push(c0 + 3, 8'h66);
    chk(cur_cnt == CW'(3), "R3 restart value", 32'(cur_cnt), 3);
    wait_until(c0 + 12);

    // Gating: hardware enable off, then masked entry
    hw_en = 0;
    strobe(2, 32'd3); c0 = cyc;
    wait_until(c0 + 5);
    chk(cur_cnt == '0, "R7 count runs while disabled", 32'(cur_cnt), 0);
    hw_en = 1;
    strobe(0, 32'h0001_0041);
    strobe(2, 32'd3); c0 = cyc;
    wait_until(c0 + 5);
    chk(cur_cnt == '0, "R7 masked expiry", 32'(cur_cnt), 0);

    // Software enable low forces the mask
    strobe(0, 32'h0000_0041);
    sw_en = 0;
    repeat (2) @(negedge clk);
    chk(entry_q == 32'h0001_0041, "R9 mask set on disable", entry_q, 32'h0001_0041);
    strobe(0, 32'h0000_0077);
    chk(entry_q == 32'h0001_0077, "R9 write forced masked", entry_q, 32'h0001_0077);
    strobe(2, 32'd2); c0 = cyc;
    wait_until(c0 + 5);
    sw_en = 1;
    strobe(0, 32'h0000_0077);
    chk(entry_q == 32'h0000_0077, "R9 unmask after enable", entry_q, 32'h77);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R4 missing requests", 32'(sb.size()), 0);
    finish_run();
  end
endmodule